// File: doc/BRIEF.md
# Decimating Audio Block Framer

This block sits between a codec capture path and a frame-based pitch or correlation engine. It receives signed 16-bit audio samples, each marked by a valid strobe, at the codec rate of about 44 kHz. It keeps the first valid sample of every group of four, which gives an effective rate of about 11 kHz. Each kept sample is halved with an arithmetic shift, so that later multiply-accumulate work has headroom. The kept samples are collected into frames of 330 entries, which is 30 ms of decimated audio.

Two storage banks take turns. One bank collects the frame that is filling. The other bank holds the last finished frame and serves a synchronous random-access read port. When the last entry of a frame is written, the banks trade roles and a one-cycle ready pulse tells the analysis side that a new frame can be read. Capture never stops. If the analysis side reports that it is still busy when a frame completes, the block sets a sticky overrun flag and swaps the banks anyway.

Top module: `audio_frame_decimator`

## Requirements
- R1: After reset, the first valid input sample is kept, and after that every fourth valid sample is kept. Cycles with smp_valid_i low do not advance the decimation count, and the data on them is never stored.
- R2: A kept sample is stored as the input value shifted right by one with sign extension (for example 16'h8000 is stored as 16'hC000 and 16'hFFFF as 16'hFFFF).
- R3: A frame holds 330 kept samples. The kept sample with frame position k (k = 0 to 329, in arrival order) is read at rd_addr_i = k.
- R4: frame_ready_o is high for exactly one cycle. It rises in the cycle right after the clock edge that writes the 330th kept sample of a frame, and it pulses once per frame.
- R5: The read port addresses the most recently completed frame. rd_data_o shows the entry at rd_addr_i one clock edge after the address is presented. After each frame_ready_o pulse, reads return the new frame.
- R6: While the next frame is filling, the completed frame seen at the read port does not change.
- R7: If rd_busy_i is high on the edge that completes a frame, overrun_o goes high and stays high until reset, and the banks still swap.
- R8: Reset (rst_ni low) clears frame_ready_o, overrun_o, the decimation count and the write position, so a frame that was partly filled is discarded.
- R9: A frame that completes while rd_busy_i is low leaves overrun_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | 16 | Signed input sample |
| rd_busy_i | input | 1 | Analysis side still using the completed frame |
| rd_addr_i | input | 9 | Read address into the completed frame |
| rd_data_o | output | 16 | Registered read data |
| frame_ready_o | output | 1 | One-cycle pulse when a new frame is available |
| overrun_o | output | 1 | Sticky flag: a frame completed while the reader was busy |

## Verification
The hardest situation to reach from the ports is a frame boundary that happens while the reader is busy, and then proving that the bank swapped anyway and that the flag stays set through the next, clean boundary. The stimulus walks whole frames of 1320 input samples. It leaves idle cycles with distinct junk data between valid samples, raises the busy input only around the completing sample of the second frame, and reads the first frame back from the middle of the next fill. A partial fill followed by a reset then shows that capture restarts on a kept sample at position zero.

// File: rtl/afd_pkg.sv
package afd_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/afd_decimator.sv
module afd_decimator #(
  parameter int SAMPLE_W = 16,
  parameter int DECIM    = 4,
  parameter int SHIFT    = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                keep_o,
  output logic [SAMPLE_W-1:0] data_o
);
  localparam int PH_W = (DECIM > 1) ? $clog2(DECIM) : 1;

  logic [PH_W-1:0]            phase_q;
  logic signed [SAMPLE_W-1:0] sdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (valid_i) begin
      if (phase_q == PH_W'(DECIM - 1)) phase_q <= '0;
      else                             phase_q <= phase_q + 1'b1;
    end
  end

  assign keep_o = valid_i && (phase_q == '0);
  assign sdata  = data_i;
  assign data_o = sdata >>> SHIFT;
endmodule

// File: rtl/afd_frame_ctrl.sv
module afd_frame_ctrl
  import afd_pkg::*;
#(
  parameter int FRAME_LEN = 330,
  parameter int IDX_W     = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             keep_i,
  input  logic             rd_busy_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output bank_e            wr_bank_o,
  output logic             frame_ready_o,
  output logic             overrun_o
);
  logic [IDX_W-1:0] idx_q;
  bank_e            bank_q;
  logic             ready_q;
  logic             ovr_q;
  logic             last;

  assign last = keep_i && (idx_q == IDX_W'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      bank_q  <= BANK_A;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ready_q <= last;
      if (last) begin
        idx_q  <= '0;
        bank_q <= bank_e'(~bank_q);
        if (rd_busy_i) ovr_q <= 1'b1;
      end else if (keep_i) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign wr_idx_o      = idx_q;
  assign wr_bank_o     = bank_q;
  assign frame_ready_o = ready_q;
  assign overrun_o     = ovr_q;
endmodule

// File: rtl/afd_bank.sv
module afd_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 330,
  parameter int IDX_W  = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/audio_frame_decimator.sv
module audio_frame_decimator
  import afd_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int DECIM     = 4,
  parameter int SHIFT     = 1,
  parameter int FRAME_LEN = 330,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic                rd_busy_i,
  input  logic [IDX_W-1:0]    rd_addr_i,
  output logic [SAMPLE_W-1:0] rd_data_o,
  output logic                frame_ready_o,
  output logic                overrun_o
);
  localparam int NBANK = 2;

  logic                keep;
  logic [SAMPLE_W-1:0] scaled;
  logic [IDX_W-1:0]    wr_idx;
  bank_e               wr_bank;
  bank_e               rd_bank;
  bank_e               rd_sel_q;
  logic [SAMPLE_W-1:0] bank_rdata [NBANK];

  afd_decimator #(
    .SAMPLE_W(SAMPLE_W),
    .DECIM   (DECIM),
    .SHIFT   (SHIFT)
  ) u_decim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(smp_valid_i),
    .data_i (smp_data_i),
    .keep_o (keep),
    .data_o (scaled)
  );

  afd_frame_ctrl #(
    .FRAME_LEN(FRAME_LEN),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .keep_i       (keep),
    .rd_busy_i    (rd_busy_i),
    .wr_idx_o     (wr_idx),
    .wr_bank_o    (wr_bank),
    .frame_ready_o(frame_ready_o),
    .overrun_o    (overrun_o)
  );

  assign rd_bank = bank_e'(~wr_bank);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    afd_bank #(
      .DATA_W(SAMPLE_W),
      .DEPTH (FRAME_LEN),
      .IDX_W (IDX_W)
    ) u_bank (
      .clk_i  (clk_i),
      .we_i   (keep && (wr_bank == bank_e'(b))),
      .waddr_i(wr_idx),
      .wdata_i(scaled),
      .raddr_i(rd_addr_i),
      .rdata_o(bank_rdata[b])
    );
  end

  // read select follows the bank that was readable when the address was sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_sel_q <= BANK_B;
    else         rd_sel_q <= rd_bank;
  end

  assign rd_data_o = bank_rdata[rd_sel_q];
endmodule

// File: rtl/afd_checker.sv
module afd_checker
  import afd_pkg::*;
#(
  parameter int FRAME_LEN = 330,
  parameter int IDX_W     = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             keep,
  input logic [IDX_W-1:0] wr_idx,
  input bank_e            rd_bank,
  input logic             rd_busy_i,
  input logic             frame_ready_o,
  input logic             overrun_o
);
  // R1: two kept samples never on consecutive cycles
  p_keep_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep |=> !keep);

  // R3: write position stays inside the frame
  p_idx_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_idx < IDX_W'(FRAME_LEN));

  // R4: single-cycle pulse following a kept write
  p_ready_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |=> !frame_ready_o);
  p_ready_after_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_ready_o) |-> $past(keep));
  p_ready_idx_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> wr_idx == '0);

  // R5: readable bank changes exactly at frame completion
  p_bank_swap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ready_o |-> rd_bank != $past(rd_bank));
  p_bank_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_ready_o |-> $stable(rd_bank));

  // R7: sticky, and only set by a busy completion
  p_overrun_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  p_overrun_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> frame_ready_o && $past(rd_busy_i));
endmodule

bind audio_frame_decimator afd_checker #(
  .FRAME_LEN(FRAME_LEN),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .keep         (keep),
  .wr_idx       (wr_idx),
  .rd_bank      (rd_bank),
  .rd_busy_i    (rd_busy_i),
  .frame_ready_o(frame_ready_o),
  .overrun_o    (overrun_o)
);

// File: tb/audio_frame_decimator_tb.sv
module audio_frame_decimator_tb;
  localparam int FL = 330;
  localparam int DC = 4;

  // {raw input, expected stored value} for the first kept samples of frame 0
  localparam logic [31:0] VEC [8] = '{
    {16'h7FFF, 16'h3FFF}, {16'h8000, 16'hC000}, {16'hFFFF, 16'hFFFF},
    {16'h0001, 16'h0000}, {16'h0000, 16'h0000}, {16'hC001, 16'hE000},
    {16'h1234, 16'h091A}, {16'hFFFE, 16'hFFFF}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [15:0] smp_data_i = '0;
  logic        rd_busy_i = 1'b0;
  logic [8:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        frame_ready_o;
  logic        overrun_o;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit finished = 0;
  logic [15:0] exp_cur  [FL];
  logic [15:0] exp_prev [FL];

  always #4 clk = ~clk;

  audio_frame_decimator u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .smp_valid_i  (smp_valid_i),
    .smp_data_i   (smp_data_i),
    .rd_busy_i    (rd_busy_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o),
    .frame_ready_o(frame_ready_o),
    .overrun_o    (overrun_o)
  );

  always @(negedge clk) if (rst_ni && frame_ready_o) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] raw_of(int f, int k);
    if (f == 0 && k < 8) return VEC[k][31:16];
    return 16'((k * 613 + f * 4099 + 11) ^ 32'h9C3B);
  endfunction

  function automatic logic [15:0] half(logic [15:0] v);
    logic signed [15:0] s;
    s = v;
    return {s[15], s[15:1]};
  endfunction

  // one idle cycle with junk data, then one valid cycle; returns after the capture edge
  task automatic push(logic [15:0] v);
    @(negedge clk);
    smp_valid_i = 1'b1;
    smp_data_i  = v;
    @(negedge clk);
    smp_valid_i = 1'b0;
    smp_data_i  = 16'hDEAD;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    rd_addr_i = 9'(a);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic run_frame(int f, bit busy_end, bit mid_chk);
    logic [15:0] d;
    for (int k = 0; k < FL; k++) exp_prev[k] = exp_cur[k];
    for (int n = 0; n < FL * DC; n++) begin
      int k = n / DC;
      if (n % DC == 0) begin
        exp_cur[k] = (f == 0 && k < 8) ? VEC[k][15:0] : half(raw_of(f, k));
        if (n == (FL - 1) * DC) rd_busy_i = busy_end;
        push(raw_of(f, k));
      end else begin
        push(16'h5A5A ^ 16'(n));
      end
      if (n == (FL - 1) * DC - DC) chk("R4 no early ready", 32'(frame_ready_o), 0);
      if (n == (FL - 1) * DC) begin
        chk("R4 ready after last write", 32'(frame_ready_o), 1);
        @(negedge clk);
        chk("R4 ready one cycle", 32'(frame_ready_o), 0);
        rd_busy_i = 1'b0;
      end
      if (mid_chk && n == 400) begin
        rd(0, d);  chk("R6 old frame addr 0", 32'(d), 32'(exp_prev[0]));
        rd(1, d);  chk("R6 old frame addr 1", 32'(d), 32'(exp_prev[1]));
        rd(FL - 1, d); chk("R6 old frame last", 32'(d), 32'(exp_prev[FL - 1]));
      end
    end
  endtask

  task automatic read_all(string req);
    logic [15:0] d;
    for (int a = 0; a < FL; a++) begin
      rd(a, d);
      chk(req, 32'(d), 32'(exp_cur[a]));
    end
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    chk("R8 reset ready", 32'(frame_ready_o), 0);
    chk("R8 reset overrun", 32'(overrun_o), 0);
    rst_ni = 1'b1;

    // frame 0: scaling table, busy low at completion
    run_frame(0, 1'b0, 1'b0);
    chk("R9 no overrun when idle", 32'(overrun_o), 0);
    for (int i = 0; i < 8; i++) begin
      rd(i, d);
      chk("R2 scaled sample", 32'(d), 32'(VEC[i][15:0]));
    end
    read_all("R3 frame 0 contents");

    // frame 1: old frame read mid-fill, busy at completion
    run_frame(1, 1'b1, 1'b1);
    chk("R7 overrun set", 32'(overrun_o), 1);
    read_all("R7 R5 swapped to frame 1");

    // frame 2: clean completion, flag stays
    run_frame(2, 1'b0, 1'b1);
    chk("R7 overrun sticky", 32'(overrun_o), 1);
    read_all("R5 frame 2 contents");

    // partial fill, then reset
    push(16'h1111); push(16'h2222); push(16'h3333);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R8 overrun cleared", 32'(overrun_o), 0);
    chk("R8 ready cleared", 32'(frame_ready_o), 0);
    rst_ni = 1'b1;
    run_frame(3, 1'b0, 1'b0);
    read_all("R1 R8 restart on kept sample");
    chk("R9 overrun clear after reset", 32'(overrun_o), 0);
    chk("R4 one pulse per frame", 32'(pulses), 4);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule